// File: doc/BRIEF.md
# Per-Channel Inverse Gamma Lookup with Non-Volatile Table Store

This block corrects the gray level of a 24-bit RGB pixel stream. Each 8-bit colour field addresses its own 256-entry table and gets back a 16-bit corrected value. The three tables always hold the same correction curve. Pixel lookups read through one port of each table. All loading, editing and saving goes through the other port, so the pixel stream never stalls.

After reset, a sequencer fetches 256 words from an external non-volatile store over a word-level request/acknowledge handshake. It writes each word into all three tables in the same cycle. Corrected pixels are only emitted once this load has finished. Before that, pixels are either dropped or passed through uncorrected, as a parameter selects.

Once the load is done, a control port fed from a serial link can overwrite single entries. A save command then writes the whole table, read from the first table only, back to the store. While a load or a save is running, the block reports busy and ignores new edits and new save commands.

Top module: `gamma_lut_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `init_done_o` is 0, `busy_o` is 1 and `pix_valid_o` is 0. After reset the sequencer requests a read (`nvm_we_o`=0) of word 0.
- R2: The load reads store addresses 0 to 255 in ascending order, one read per acknowledge. Each word goes into all three tables at that address. In the cycle after the 256th acknowledge, `init_done_o` rises and `busy_o` falls. `init_done_o` then stays 1 until reset.
- R3: `nvm_req_o` stays high, and `nvm_addr_o`, `nvm_we_o` and `nvm_wdata_o` stay stable, until the clock edge at which `nvm_ack_i` is high. That edge completes the transfer, and `nvm_rdata_i` is sampled at it.
- R4: `pix_rgb_i` is {red[23:16], green[15:8], blue[7:0]}. `pix_data_o` is {T[red] at [47:32], T[green] at [31:16], T[blue] at [15:0]}, where T is the table. The result appears one clock after the input.
- R5: `pix_valid_o` and `pix_sync_o` follow `pix_valid_i` and `pix_sync_i` with exactly one clock of delay. The only exception is valid being suppressed under R6.
- R6: Before `init_done_o` is 1, with PASS_EARLY=0 no pixel is emitted (`pix_valid_o`=0). With PASS_EARLY=1 the pixel is emitted, and each 16-bit channel holds its 8-bit input zero-extended.
- R7: `cfg_we_i` while `busy_o` is 0 writes `cfg_data_i` to entry `cfg_addr_i` of all three tables. A lookup presented in the same cycle returns the old value. Lookups from the next cycle on return the new value.
- R8: `cfg_we_i` while `busy_o` is 1 changes no entry.
- R9: `save_req_i` while `busy_o` is 0 raises `busy_o` in the next cycle. It then writes (`nvm_we_o`=1) all 256 table entries to store addresses 0 to 255 in ascending order. `busy_o` falls after the last acknowledge.
- R10: `save_req_i` while `busy_o` is 1 starts no additional transfer.
- R11: Pixels presented on every cycle during a save or an edit are all looked up and emitted with the R4 latency. There is no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Input pixel qualifier |
| pix_sync_i | input | 1 | Input sync marker, carried with the pixel |
| pix_rgb_i | input | 24 | Input pixel {R,G,B} |
| pix_valid_o | output | 1 | Output pixel qualifier |
| pix_sync_o | output | 1 | Delayed sync marker |
| pix_data_o | output | 48 | Corrected pixel {R,G,B}, 16 bits per channel |
| cfg_we_i | input | 1 | Table entry write strobe |
| cfg_addr_i | input | 8 | Table entry index |
| cfg_data_i | input | 16 | Table entry value |
| save_req_i | input | 1 | Start copying the table to the store |
| busy_o | output | 1 | Load or save in progress |
| init_done_o | output | 1 | Table load finished |
| nvm_req_o | output | 1 | Store transfer request |
| nvm_we_o | output | 1 | 1 = write to store, 0 = read |
| nvm_addr_o | output | 8 | Store word address |
| nvm_wdata_o | output | 16 | Word to write |
| nvm_ack_i | input | 1 | Store acknowledge, ends the transfer |
| nvm_rdata_i | input | 16 | Word read, valid with the acknowledge |

## Verification
A wrong table entry shows up on `pix_data_o` one clock after any pixel whose field hits that index. It shows up again in the store contents after the next save. A sequencer that skips, repeats or reorders an address is visible at once on `nvm_addr_o` at the next acknowledge. An edit that leaks through while busy stays hidden until a later lookup of that index, so the bench looks up the targeted entry right after the save. A slip in the pixel pipeline misaligns valid, sync and data on the very next cycle.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  typedef enum logic [1:0] {
    SQ_LOAD,
    SQ_IDLE,
    SQ_SAVE_RD,
    SQ_SAVE_WR
  } seq_state_e;
endpackage

// File: rtl/gamma_lut_ram.sv
module gamma_lut_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic [AW-1:0] a_addr_i,
  output logic [DW-1:0] a_q_o,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wd_i,
  output logic [DW-1:0] b_q_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // both read ports return the pre-write contents on a collision
  always_ff @(posedge clk_i) begin
    if (b_we_i) mem[b_addr_i] <= b_wd_i;
    a_q_o <= mem[a_addr_i];
    b_q_o <= mem[b_addr_i];
  end
endmodule

// File: rtl/gamma_nvm_seq.sv
module gamma_nvm_seq
  import gamma_lut_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [DW-1:0] cfg_data_i,
  input  logic          save_req_i,
  input  logic [DW-1:0] tbl_rd_i,
  output logic          tbl_we_o,
  output logic [AW-1:0] tbl_addr_o,
  output logic [DW-1:0] tbl_wd_o,
  output logic          busy_o,
  output logic          init_done_o,
  output logic          nvm_req_o,
  output logic          nvm_we_o,
  output logic [AW-1:0] nvm_addr_o,
  output logic [DW-1:0] nvm_wdata_o,
  input  logic          nvm_ack_i,
  input  logic [DW-1:0] nvm_rdata_i
);
  seq_state_e    state_q, state_d;
  logic [AW-1:0] idx_q, idx_d;
  logic          done_d;
  logic          last;

  assign last = (idx_q == {AW{1'b1}});

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    done_d      = init_done_o;
    tbl_we_o    = 1'b0;
    tbl_addr_o  = idx_q;
    tbl_wd_o    = nvm_rdata_i;
    nvm_req_o   = 1'b0;
    nvm_we_o    = 1'b0;
    nvm_wdata_o = '0;
    unique case (state_q)
      SQ_LOAD: begin
        nvm_req_o = 1'b1;
        if (nvm_ack_i) begin
          tbl_we_o = 1'b1;
          idx_d    = idx_q + 1'b1;
          if (last) begin
            state_d = SQ_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      SQ_IDLE: begin
        tbl_we_o   = cfg_we_i;
        tbl_addr_o = cfg_addr_i;
        tbl_wd_o   = cfg_data_i;
        if (save_req_i) begin
          state_d = SQ_SAVE_RD;
          idx_d   = '0;
        end
      end
      SQ_SAVE_RD: state_d = SQ_SAVE_WR;  // table read latency
      SQ_SAVE_WR: begin
        nvm_req_o   = 1'b1;
        nvm_we_o    = 1'b1;
        nvm_wdata_o = tbl_rd_i;
        if (nvm_ack_i) begin
          idx_d   = idx_q + 1'b1;
          state_d = last ? SQ_IDLE : SQ_SAVE_RD;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SQ_LOAD;
      idx_q       <= '0;
      init_done_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      idx_q       <= idx_d;
      init_done_o <= done_d;
    end
  end

  assign busy_o     = (state_q != SQ_IDLE);
  assign nvm_addr_o = idx_q;
endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top #(
  parameter int CH_W       = 8,
  parameter int OUT_W      = 16,
  parameter int NCH        = 3,
  parameter bit PASS_EARLY = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pix_valid_i,
  input  logic                 pix_sync_i,
  input  logic [NCH*CH_W-1:0]  pix_rgb_i,
  output logic                 pix_valid_o,
  output logic                 pix_sync_o,
  output logic [NCH*OUT_W-1:0] pix_data_o,
  input  logic                 cfg_we_i,
  input  logic [CH_W-1:0]      cfg_addr_i,
  input  logic [OUT_W-1:0]     cfg_data_i,
  input  logic                 save_req_i,
  output logic                 busy_o,
  output logic                 init_done_o,
  output logic                 nvm_req_o,
  output logic                 nvm_we_o,
  output logic [CH_W-1:0]      nvm_addr_o,
  output logic [OUT_W-1:0]     nvm_wdata_o,
  input  logic                 nvm_ack_i,
  input  logic [OUT_W-1:0]     nvm_rdata_i
);
  localparam int PAD_W = OUT_W - CH_W;

  logic                tbl_we;
  logic [CH_W-1:0]     tbl_addr;
  logic [OUT_W-1:0]    tbl_wd;
  logic [OUT_W-1:0]    save_rd;
  logic                vld_q, sync_q, byp_q;
  logic [NCH*CH_W-1:0] raw_q;

  gamma_nvm_seq #(.AW(CH_W), .DW(OUT_W)) seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_data_i  (cfg_data_i),
    .save_req_i  (save_req_i),
    .tbl_rd_i    (save_rd),
    .tbl_we_o    (tbl_we),
    .tbl_addr_o  (tbl_addr),
    .tbl_wd_o    (tbl_wd),
    .busy_o      (busy_o),
    .init_done_o (init_done_o),
    .nvm_req_o   (nvm_req_o),
    .nvm_we_o    (nvm_we_o),
    .nvm_addr_o  (nvm_addr_o),
    .nvm_wdata_o (nvm_wdata_o),
    .nvm_ack_i   (nvm_ack_i),
    .nvm_rdata_i (nvm_rdata_i)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [OUT_W-1:0] lut_q;
    if (c == 0) begin : g_rd
      gamma_lut_ram #(.AW(CH_W), .DW(OUT_W)) ram_i (
        .clk_i    (clk_i),
        .a_addr_i (pix_rgb_i[c*CH_W +: CH_W]),
        .a_q_o    (lut_q),
        .b_we_i   (tbl_we),
        .b_addr_i (tbl_addr),
        .b_wd_i   (tbl_wd),
        .b_q_o    (save_rd)
      );
    end else begin : g_nrd
      logic [OUT_W-1:0] b_q_unused;
      gamma_lut_ram #(.AW(CH_W), .DW(OUT_W)) ram_i (
        .clk_i    (clk_i),
        .a_addr_i (pix_rgb_i[c*CH_W +: CH_W]),
        .a_q_o    (lut_q),
        .b_we_i   (tbl_we),
        .b_addr_i (tbl_addr),
        .b_wd_i   (tbl_wd),
        .b_q_o    (b_q_unused)
      );
    end
    assign pix_data_o[c*OUT_W +: OUT_W] =
      byp_q ? {{PAD_W{1'b0}}, raw_q[c*CH_W +: CH_W]} : lut_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      sync_q <= 1'b0;
      byp_q  <= 1'b1;
      raw_q  <= '0;
    end else begin
      vld_q  <= pix_valid_i & (init_done_o | PASS_EARLY);
      sync_q <= pix_sync_i;
      byp_q  <= ~init_done_o;
      raw_q  <= pix_rgb_i;
    end
  end

  assign pix_valid_o = vld_q;
  assign pix_sync_o  = sync_q;
endmodule

// File: rtl/gamma_lut_checker.sv
module gamma_lut_checker #(
  parameter int CH_W       = 8,
  parameter int OUT_W      = 16,
  parameter bit PASS_EARLY = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_valid_i,
  input logic             pix_sync_i,
  input logic             pix_valid_o,
  input logic             pix_sync_o,
  input logic             busy_o,
  input logic             init_done_o,
  input logic             nvm_req_o,
  input logic             nvm_we_o,
  input logic [CH_W-1:0]  nvm_addr_o,
  input logic [OUT_W-1:0] nvm_wdata_o,
  input logic             nvm_ack_i
);
  a_r3_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nvm_req_o && !nvm_ack_i |=> nvm_req_o && $stable(nvm_addr_o) &&
                               $stable(nvm_we_o) && $stable(nvm_wdata_o));

  a_r5_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> $past(pix_valid_i));

  a_r5_sync_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_sync_i |=> pix_sync_o);

  a_r5_sync_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_sync_i |=> !pix_sync_o);

  a_r2_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  a_r2_load_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o && nvm_req_o |-> !nvm_we_o);

  a_r9_save_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o && nvm_req_o |-> nvm_we_o);

  a_r10_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nvm_req_o |-> busy_o);

  if (!PASS_EARLY) begin : g_drop
    a_r6_drop_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !init_done_o |=> !pix_valid_o);
  end
endmodule

bind gamma_lut_top gamma_lut_checker #(
  .CH_W(CH_W), .OUT_W(OUT_W), .PASS_EARLY(PASS_EARLY)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pix_valid_i (pix_valid_i),
  .pix_sync_i  (pix_sync_i),
  .pix_valid_o (pix_valid_o),
  .pix_sync_o  (pix_sync_o),
  .busy_o      (busy_o),
  .init_done_o (init_done_o),
  .nvm_req_o   (nvm_req_o),
  .nvm_we_o    (nvm_we_o),
  .nvm_addr_o  (nvm_addr_o),
  .nvm_wdata_o (nvm_wdata_o),
  .nvm_ack_i   (nvm_ack_i)
);

// File: tb/gamma_lut_top_tb_top.sv
module gamma_lut_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        pix_valid = 0, pix_sync = 0;
  logic [23:0] pix_rgb = '0;
  logic        cfg_we = 0, save_req = 0;
  logic [7:0]  cfg_addr = '0;
  logic [15:0] cfg_data = '0;
  logic        nvm_ack = 0;
  logic [15:0] nvm_rdata = '0;

  logic        pix_valid_o, pix_sync_o, busy_o, init_done_o;
  logic [47:0] pix_data_o;
  logic        nvm_req_o, nvm_we_o;
  logic [7:0]  nvm_addr_o;
  logic [15:0] nvm_wdata_o;

  logic        p_valid_o, p_sync_o, p_busy_o, p_done_o, p_req_o, p_we_o;
  logic [47:0] p_data_o;
  logic [7:0]  p_addr_o;
  logic [15:0] p_wdata_o;

  gamma_lut_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .pix_valid_i(pix_valid), .pix_sync_i(pix_sync), .pix_rgb_i(pix_rgb),
    .pix_valid_o(pix_valid_o), .pix_sync_o(pix_sync_o), .pix_data_o(pix_data_o),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .save_req_i(save_req), .busy_o(busy_o), .init_done_o(init_done_o),
    .nvm_req_o(nvm_req_o), .nvm_we_o(nvm_we_o), .nvm_addr_o(nvm_addr_o),
    .nvm_wdata_o(nvm_wdata_o), .nvm_ack_i(nvm_ack), .nvm_rdata_i(nvm_rdata)
  );

  gamma_lut_top #(.PASS_EARLY(1'b1)) dut_pass_i (
    .clk_i(clk), .rst_ni(rst_n),
    .pix_valid_i(pix_valid), .pix_sync_i(pix_sync), .pix_rgb_i(pix_rgb),
    .pix_valid_o(p_valid_o), .pix_sync_o(p_sync_o), .pix_data_o(p_data_o),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .save_req_i(save_req), .busy_o(p_busy_o), .init_done_o(p_done_o),
    .nvm_req_o(p_req_o), .nvm_we_o(p_we_o), .nvm_addr_o(p_addr_o),
    .nvm_wdata_o(p_wdata_o), .nvm_ack_i(1'b0), .nvm_rdata_i(16'h0000)
  );

  logic [15:0] eep [256];
  logic [15:0] tbl [256];
  int n_chk = 0, n_err = 0, rd_cnt = 0, wr_cnt = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] seed_word(input int i);
    return 16'((i * i * 37 + i * 11 + 341) ^ (i << 7));
  endfunction

  function automatic logic [47:0] exp_pix(input logic [23:0] rgb);
    return {tbl[rgb[23:16]], tbl[rgb[15:8]], tbl[rgb[7:0]]};
  endfunction

  // store model: random acknowledge latency 0..2, checks address order
  initial begin
    int wait_c = 0;
    forever begin
      @(negedge clk);
      if (nvm_ack) nvm_ack = 1'b0;
      else if (nvm_req_o && rst_n) begin
        if (wait_c == 0) begin
          nvm_ack = 1'b1;
          wait_c = int'($urandom % 3);
          if (nvm_we_o) begin
            chk(nvm_addr_o == 8'(wr_cnt), "R9 save address order", nvm_addr_o, 8'(wr_cnt));
            eep[nvm_addr_o] = nvm_wdata_o;
            wr_cnt++;
          end else begin
            chk(nvm_addr_o == 8'(rd_cnt), "R2 load address order", nvm_addr_o, 8'(rd_cnt));
            nvm_rdata = eep[nvm_addr_o];
            rd_cnt++;
          end
        end else wait_c--;
      end
    end
  end

  bit          have = 0;
  bit          e_v, e_s;
  logic [47:0] e_d;
  string       e_tag;

  task automatic step(input logic [23:0] rgb, input bit v, input bit s,
                      input bit we, input logic [7:0] wa, input logic [15:0] wd,
                      input bit apply, input bit sv, input string tag);
    @(negedge clk);
    if (have) begin
      chk(pix_valid_o == e_v, {e_tag, " R5 valid"}, pix_valid_o, e_v);
      chk(pix_sync_o == e_s, {e_tag, " R5 sync"}, pix_sync_o, e_s);
      if (e_v) chk(pix_data_o == e_d, {e_tag, " R4 data"}, pix_data_o, e_d);
    end
    pix_rgb = rgb; pix_valid = v; pix_sync = s;
    cfg_we = we; cfg_addr = wa; cfg_data = wd; save_req = sv;
    e_v = v; e_s = s; e_d = exp_pix(rgb); e_tag = tag; have = 1;
    if (we && apply) tbl[wa] = wd;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [23:0] prev_rgb;
    bit prev_s;
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 256; i++) eep[i] = seed_word(i);
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(init_done_o == 0 && busy_o == 1 && pix_valid_o == 0, "R1 reset state",
        {init_done_o, busy_o, pix_valid_o}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(init_done_o == 0 && busy_o == 1 && pix_valid_o == 0, "R1 after reset",
        {init_done_o, busy_o, pix_valid_o}, 3'b010);
    chk(nvm_req_o && !nvm_we_o && nvm_addr_o == 0, "R1 first read",
        {nvm_req_o, nvm_we_o, nvm_addr_o}, 10'h200);

    // R6: pixels during load, dropped or passed through
    prev_rgb = '0; prev_s = 0;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) begin
        chk(pix_valid_o == 0, "R6 drop before load", pix_valid_o, 0);
        chk(p_valid_o == 1, "R6 pass valid", p_valid_o, 1);
        chk(p_sync_o == prev_s, "R5 sync pass", p_sync_o, prev_s);
        chk(p_data_o == {8'h0, prev_rgb[23:16], 8'h0, prev_rgb[15:8], 8'h0, prev_rgb[7:0]},
            "R6 pass data", p_data_o,
            {8'h0, prev_rgb[23:16], 8'h0, prev_rgb[15:8], 8'h0, prev_rgb[7:0]});
      end
      prev_rgb = 24'($urandom); prev_s = i[0];
      pix_rgb = prev_rgb; pix_valid = 1; pix_sync = prev_s;
      @(negedge clk);
    end
    pix_valid = 0; pix_sync = 0;

    while (!init_done_o) @(negedge clk);
    chk(rd_cnt == 256, "R2 read count", rd_cnt, 256);
    chk(busy_o == 0, "R2 busy falls", busy_o, 0);
    for (int i = 0; i < 256; i++) tbl[i] = eep[i];

    // R4 directed corners then random
    step(24'h000000, 1, 1, 0, 0, 0, 0, 0, "R4 zero");
    step(24'hFFFFFF, 1, 0, 0, 0, 0, 0, 0, "R4 ones");
    step(24'h00FF80, 1, 1, 0, 0, 0, 0, 0, "R4 mixed");
    step(24'h7F0001, 0, 1, 0, 0, 0, 0, 0, "R5 idle");
    repeat (300) step(24'($urandom), ($urandom % 4) != 0, 1'($urandom), 0, 0, 0, 0, 0, "R4 random");

    // R7 write with same-cycle and next-cycle lookup
    for (int k = 0; k < 8; k++) begin
      logic [7:0] a;
      logic [15:0] d;
      a = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'($urandom);
      d = 16'($urandom);
      step({a, a, a}, 1, 0, 1, a, d, 1, 0, "R7 old value");
      step({a, a, a}, 1, 0, 0, 0, 0, 0, 0, "R7 new value");
    end
    repeat (100) step(24'($urandom), 1, 1'($urandom), ($urandom % 3) == 0,
                      8'($urandom), 16'($urandom), 1, 0, "R11 edits");

    // R9 save with R8/R10 stimulus in flight
    step(24'($urandom), 1, 0, 0, 0, 0, 0, 1, "R11 save start");
    step(24'($urandom), 1, 0, 0, 0, 0, 0, 0, "R11 save");
    chk(busy_o == 1, "R9 busy rises", busy_o, 1);
    for (int i = 0; i < 3000 && busy_o; i++)
      step(24'($urandom), 1, 1'($urandom), i == 10, 8'h05, ~tbl[5], 0, i == 20, "R11 during save");
    step(24'h050505, 1, 0, 0, 0, 0, 0, 0, "R8 edit ignored");
    step(24'h000000, 0, 0, 0, 0, 0, 0, 0, "R5 flush");
    chk(busy_o == 0 && nvm_req_o == 0, "R9 save ends", {busy_o, nvm_req_o}, 0);
    repeat (50) @(negedge clk);
    chk(wr_cnt == 256, "R10 single save", wr_cnt, 256);
    for (int i = 0; i < 256; i++)
      chk(eep[i] == tbl[i], "R9 stored word", eep[i], tbl[i]);

    // R7 edits accepted again after save
    step(24'h333333, 1, 0, 1, 8'h33, 16'hBEEF, 1, 0, "R7 post save old");
    step(24'h333333, 1, 0, 0, 0, 0, 0, 0, "R7 post save new");
    step(24'h0, 0, 0, 0, 0, 0, 0, 0, "R5 flush");
    step(24'h0, 0, 0, 0, 0, 0, 0, 0, "R5 flush");
    finish_run();
  end
endmodule